// File: doc/BRIEF.md
# Shared Address/Data Bus Splitter

This block sits between a processor whose low address byte and data byte share one set of lines and a system bus that has a separate address bus, a separate data bus and discrete command strobes. A latch-enable pulse from the processor marks the address phase. During that phase the block captures the low address byte from the shared lines. The upper address byte arrives on dedicated lines and goes straight through. Together these form the full system address.

The processor's read and write strobes are combined with its space-select line to produce four active-low strobes: memory read, memory write, IO read and IO write. An interrupt-acknowledge strobe is passed through. Both data buses are bidirectional. Each is modelled as an input, an output and an output enable. The block drives the system data bus while a write is in progress, and it drives the shared lines while a read is in progress. Neither bus is driven during the address phase.

All logic runs on one clock with an active-low asynchronous reset. The low-address holding register is clocked. The strobes and the enables are combinational from the current inputs, so a strobe follows its source in the same cycle.

Top module: `muxbus_splitter`

## Requirements
- R1: Output address bits 15:8 always equal the dedicated upper-address input `hi_addr`.
- R2: While `ale` is high and reset is released, output address bits 7:0 follow `ad_in` in the same cycle. This is the transparent address phase.
- R3: On every rising clock edge where `ale` is high, the low byte is stored. While `ale` stays low, output address bits 7:0 keep the value of `ad_in` from the last such edge, even when `ad_in` changes.
- R4: `io_sel` high selects the IO space and low selects memory. `mem_rd_n` is low only when `rd_n` is low, `wr_n` is high and `io_sel` is low. `io_rd_n` is low only when `rd_n` is low, `wr_n` is high and `io_sel` is high.
- R5: `mem_wr_n` is low only when `wr_n` is low, `rd_n` is high and `io_sel` is low. `io_wr_n` is low only when `wr_n` is low, `rd_n` is high and `io_sel` is high.
- R6: At most one of the four read/write strobes is low at any time. When `rd_n` and `wr_n` are both low, all four stay high.
- R7: `int_ack_n` equals `inta_n` while reset is released.
- R8: `sys_d_oe` is high exactly when `wr_n` is low, `rd_n` is high and `ale` is low. While it is high, `sys_d_out` equals `ad_in`. Otherwise `sys_d_out` is zero.
- R9: `ad_oe` is high exactly when `rd_n` is low, `wr_n` is high and `ale` is low. While it is high, `ad_out` equals `sys_d_in`. Otherwise `ad_out` is zero.
- R10: While `rst_n` is low, all five strobes are high, both enables are low and the stored low address byte is zero. After release, address bits 7:0 read zero until the first `ale` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale | input | 1 | Address phase marker, high while the shared lines carry the low address byte |
| ad_in | input | 8 | Shared lines as seen by the block |
| ad_out | output | 8 | Read data driven onto the shared lines |
| ad_oe | output | 1 | Enable for driving the shared lines |
| hi_addr | input | 8 | Dedicated upper address byte |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| io_sel | input | 1 | Space select: 1 selects IO, 0 selects memory |
| inta_n | input | 1 | Processor interrupt-acknowledge strobe, active low |
| sys_addr | output | 16 | Demultiplexed system address |
| sys_d_in | input | 8 | System data bus as seen by the block |
| sys_d_out | output | 8 | Write data driven onto the system data bus |
| sys_d_oe | output | 1 | Enable for driving the system data bus |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | IO read strobe, active low |
| io_wr_n | output | 1 | IO write strobe, active low |
| int_ack_n | output | 1 | Interrupt-acknowledge strobe, active low |

## Verification
The bench builds the block with its default parameters. These are 8-bit shared lines, an 8-bit upper byte, a transparent address phase, `io_sel` active high for IO, and zeroed data outputs when undriven. Because the widths are only 8 bits, random `ad_in` traffic often repeats a byte, and the bench changes the shared lines between the address and data phases. This tests whether the held byte survives when the lines change underneath it. Random `rd_n`/`wr_n`/`io_sel`/`ale` mixes reach every strobe and enable combination, including the read-and-write conflict. Directed resets are placed in the middle of a cycle to check the clearing of the stored byte.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

   typedef enum logic {
      SPACE_MEM = 1'b0,
      SPACE_IO  = 1'b1
   } space_e;

   typedef struct packed {
      logic mem_rd;
      logic mem_wr;
      logic io_rd;
      logic io_wr;
   } cmd_t;

   localparam cmd_t CMD_IDLE = '{mem_rd: 1'b0, mem_wr: 1'b0, io_rd: 1'b0, io_wr: 1'b0};

   function automatic cmd_t build_cmd(input logic rd_act, input logic wr_act, input space_e space);
      cmd_t c;
      c = CMD_IDLE;
      if (rd_act && !wr_act) begin
         if (space == SPACE_IO) c.io_rd = 1'b1;
         else                   c.mem_rd = 1'b1;
      end else if (wr_act && !rd_act) begin
         if (space == SPACE_IO) c.io_wr = 1'b1;
         else                   c.mem_wr = 1'b1;
      end
      return c;
   endfunction

endpackage

// File: rtl/mbs_lo_latch.sv
module mbs_lo_latch #(
   parameter int W           = 8,
   parameter bit TRANSPARENT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ale,
   input  logic [W-1:0] ad_in,
   output logic [W-1:0] lo_addr
);

   logic [W-1:0] held_q;

   if (W < 1) begin : g_bad_w
      $error("mbs_lo_latch: W must be at least 1");
   end

   // store every cycle the address phase is open; hold once it closes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   held_q <= '0;
      else if (ale) held_q <= ad_in;
   end

   if (TRANSPARENT) begin : g_transparent
      always_comb begin
         if (ale && rst_n) lo_addr = ad_in;
         else              lo_addr = held_q;
      end
   end else begin : g_registered
      always_comb lo_addr = held_q;
   end

endmodule

// File: rtl/mbs_cmd_decode.sv
module mbs_cmd_decode #(
   parameter bit IO_SEL_HIGH = 1'b1
) (
   input  logic rst_n,
   input  logic rd_n,
   input  logic wr_n,
   input  logic io_sel,
   input  logic inta_n,
   output logic mem_rd_n,
   output logic mem_wr_n,
   output logic io_rd_n,
   output logic io_wr_n,
   output logic int_ack_n
);
   import mbs_pkg::*;

   space_e space;
   cmd_t   cmd;
   logic   rd_act;
   logic   wr_act;

   if (IO_SEL_HIGH) begin : g_io_high
      always_comb space = io_sel ? SPACE_IO : SPACE_MEM;
   end else begin : g_io_low
      always_comb space = io_sel ? SPACE_MEM : SPACE_IO;
   end

   always_comb begin
      rd_act = rst_n && !rd_n;
      wr_act = rst_n && !wr_n;
      cmd    = build_cmd(rd_act, wr_act, space);
   end

   always_comb begin
      mem_rd_n  = !cmd.mem_rd;
      mem_wr_n  = !cmd.mem_wr;
      io_rd_n   = !cmd.io_rd;
      io_wr_n   = !cmd.io_wr;
      int_ack_n = !(rst_n && !inta_n);
   end

endmodule

// File: rtl/mbs_data_steer.sv
module mbs_data_steer #(
   parameter int W         = 8,
   parameter bit GATE_DATA = 1'b1
) (
   input  logic         rst_n,
   input  logic         ale,
   input  logic         rd_n,
   input  logic         wr_n,
   input  logic [W-1:0] ad_in,
   input  logic [W-1:0] sys_d_in,
   output logic [W-1:0] sys_d_out,
   output logic         sys_d_oe,
   output logic [W-1:0] ad_out,
   output logic         ad_oe
);

   logic wr_phase;
   logic rd_phase;

   if (W < 1) begin : g_bad_w
      $error("mbs_data_steer: W must be at least 1");
   end

   // data phase only: address phase closed and exactly one direction active
   always_comb begin
      wr_phase = rst_n && !ale && !wr_n && rd_n;
      rd_phase = rst_n && !ale && !rd_n && wr_n;
      sys_d_oe = wr_phase;
      ad_oe    = rd_phase;
   end

   if (GATE_DATA) begin : g_gated
      always_comb begin
         sys_d_out = wr_phase ? ad_in    : '0;
         ad_out    = rd_phase ? sys_d_in : '0;
      end
   end else begin : g_open
      always_comb begin
         sys_d_out = ad_in;
         ad_out    = sys_d_in;
      end
   end

endmodule

// File: rtl/muxbus_splitter.sv
module muxbus_splitter #(
   parameter int LO_W        = 8,
   parameter int HI_W        = 8,
   parameter bit TRANSPARENT = 1'b1,
   parameter bit IO_SEL_HIGH = 1'b1,
   parameter bit GATE_DATA   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ale,
   input  logic [LO_W-1:0]      ad_in,
   output logic [LO_W-1:0]      ad_out,
   output logic                 ad_oe,
   input  logic [HI_W-1:0]      hi_addr,
   input  logic                 rd_n,
   input  logic                 wr_n,
   input  logic                 io_sel,
   input  logic                 inta_n,
   output logic [HI_W+LO_W-1:0] sys_addr,
   input  logic [LO_W-1:0]      sys_d_in,
   output logic [LO_W-1:0]      sys_d_out,
   output logic                 sys_d_oe,
   output logic                 mem_rd_n,
   output logic                 mem_wr_n,
   output logic                 io_rd_n,
   output logic                 io_wr_n,
   output logic                 int_ack_n
);

   localparam int ADDR_W = HI_W + LO_W;

   if (LO_W < 1 || HI_W < 0) begin : g_bad_width
      $error("muxbus_splitter: illegal address split");
   end
   if (ADDR_W > 64) begin : g_bad_addr
      $error("muxbus_splitter: address wider than 64 bits");
   end

   logic [LO_W-1:0] lo_addr;

   mbs_lo_latch #(
      .W           (LO_W),
      .TRANSPARENT (TRANSPARENT)
   ) i_lo_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .ale     (ale),
      .ad_in   (ad_in),
      .lo_addr (lo_addr)
   );

   if (HI_W > 0) begin : g_hi
      always_comb sys_addr = {hi_addr, lo_addr};
   end else begin : g_no_hi
      always_comb sys_addr = lo_addr;
   end

   mbs_cmd_decode #(
      .IO_SEL_HIGH (IO_SEL_HIGH)
   ) i_cmd_decode (
      .rst_n     (rst_n),
      .rd_n      (rd_n),
      .wr_n      (wr_n),
      .io_sel    (io_sel),
      .inta_n    (inta_n),
      .mem_rd_n  (mem_rd_n),
      .mem_wr_n  (mem_wr_n),
      .io_rd_n   (io_rd_n),
      .io_wr_n   (io_wr_n),
      .int_ack_n (int_ack_n)
   );

   mbs_data_steer #(
      .W         (LO_W),
      .GATE_DATA (GATE_DATA)
   ) i_data_steer (
      .rst_n     (rst_n),
      .ale       (ale),
      .rd_n      (rd_n),
      .wr_n      (wr_n),
      .ad_in     (ad_in),
      .sys_d_in  (sys_d_in),
      .sys_d_out (sys_d_out),
      .sys_d_oe  (sys_d_oe),
      .ad_out    (ad_out),
      .ad_oe     (ad_oe)
   );

endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
   parameter int LO_W        = 8,
   parameter int HI_W        = 8,
   parameter bit IO_SEL_HIGH = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 ale,
   input logic [LO_W-1:0]      ad_in,
   input logic                 ad_oe,
   input logic                 rd_n,
   input logic                 wr_n,
   input logic                 io_sel,
   input logic [HI_W+LO_W-1:0] sys_addr,
   input logic                 sys_d_oe,
   input logic                 mem_rd_n,
   input logic                 mem_wr_n,
   input logic                 io_rd_n,
   input logic                 io_wr_n,
   input logic                 int_ack_n
);

   logic is_io;
   always_comb is_io = IO_SEL_HIGH ? io_sel : !io_sel;

   // R3
   lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ale && !$past(ale) && $past(rst_n)) |-> $stable(sys_addr[LO_W-1:0]));

   // R3
   lo_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ale) && $past(rst_n)) |-> (sys_addr[LO_W-1:0] == $past(ad_in)));

   // R6
   one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({!mem_rd_n, !mem_wr_n, !io_rd_n, !io_wr_n}));

   // R6
   conflict_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n && !wr_n) |-> (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n));

   // R4
   mem_rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_rd_n |-> (!rd_n && !is_io));

   // R5
   io_wr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !io_wr_n |-> (!wr_n && is_io));

   // R8
   sys_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_d_oe |-> (!wr_n && !ale && !ad_oe));

   // R9
   ad_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> (!rd_n && !ale && !sys_d_oe));

   // R10
   always @(negedge clk) begin
      if (rst_n === 1'b0) begin
         rst_idle_chk: assert (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n && int_ack_n
                               && !sys_d_oe && !ad_oe);
      end
   end

endmodule

bind muxbus_splitter mbs_checker #(
   .LO_W        (LO_W),
   .HI_W        (HI_W),
   .IO_SEL_HIGH (IO_SEL_HIGH)
) i_mbs_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .ale       (ale),
   .ad_in     (ad_in),
   .ad_oe     (ad_oe),
   .rd_n      (rd_n),
   .wr_n      (wr_n),
   .io_sel    (io_sel),
   .sys_addr  (sys_addr),
   .sys_d_oe  (sys_d_oe),
   .mem_rd_n  (mem_rd_n),
   .mem_wr_n  (mem_wr_n),
   .io_rd_n   (io_rd_n),
   .io_wr_n   (io_wr_n),
   .int_ack_n (int_ack_n)
);

// File: tb/test_muxbus_splitter.sv
module test_muxbus_splitter;

   localparam int CLK_PERIOD = 10;
   localparam int N_RANDOM   = 3000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ale;
   logic [7:0]  ad_in;
   logic [7:0]  ad_out;
   logic        ad_oe;
   logic [7:0]  hi_addr;
   logic        rd_n;
   logic        wr_n;
   logic        io_sel;
   logic        inta_n;
   logic [15:0] sys_addr;
   logic [7:0]  sys_d_in;
   logic [7:0]  sys_d_out;
   logic        sys_d_oe;
   logic        mem_rd_n;
   logic        mem_wr_n;
   logic        io_rd_n;
   logic        io_wr_n;
   logic        int_ack_n;

   int   checks   = 0;
   int   failures = 0;
   logic [7:0] held = 8'h00;
   bit   done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   muxbus_splitter i_muxbus_splitter (
      .clk       (clk),
      .rst_n     (rst_n),
      .ale       (ale),
      .ad_in     (ad_in),
      .ad_out    (ad_out),
      .ad_oe     (ad_oe),
      .hi_addr   (hi_addr),
      .rd_n      (rd_n),
      .wr_n      (wr_n),
      .io_sel    (io_sel),
      .inta_n    (inta_n),
      .sys_addr  (sys_addr),
      .sys_d_in  (sys_d_in),
      .sys_d_out (sys_d_out),
      .sys_d_oe  (sys_d_oe),
      .mem_rd_n  (mem_rd_n),
      .mem_wr_n  (mem_wr_n),
      .io_rd_n   (io_rd_n),
      .io_wr_n   (io_wr_n),
      .int_ack_n (int_ack_n)
   );

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] exp_lo();
      if (rst_n && ale) return ad_in;
      return held;
   endfunction

   function automatic logic [3:0] exp_cmd_n();
      logic rd, wr;
      logic [3:0] s;  // {mem_rd, mem_wr, io_rd, io_wr}
      rd = rst_n && !rd_n;
      wr = rst_n && !wr_n;
      s = 4'b0000;
      if (rd && !wr) s = io_sel ? 4'b0010 : 4'b1000;
      if (wr && !rd) s = io_sel ? 4'b0001 : 4'b0100;
      return ~s;
   endfunction

   task automatic check_all();
      logic [3:0] got, exp;
      logic       e_soe, e_aoe;
      // R1
      chk(sys_addr[15:8] === hi_addr, "R1", {8'h0, sys_addr[15:8]}, {8'h0, hi_addr});
      // R2 and R3 (and R10 zero after reset)
      chk(sys_addr[7:0] === exp_lo(), (rst_n && ale) ? "R2" : "R3",
          {8'h0, sys_addr[7:0]}, {8'h0, exp_lo()});
      // R4 / R5 / R6
      got = {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n};
      exp = exp_cmd_n();
      chk(got === exp, (!rd_n && !wr_n) ? "R6" : (!rd_n ? "R4" : "R5"), {12'h0, got}, {12'h0, exp});
      // R7
      chk(int_ack_n === (rst_n ? inta_n : 1'b1), "R7", {15'h0, int_ack_n}, {15'h0, inta_n});
      // R8
      e_soe = rst_n && !wr_n && rd_n && !ale;
      chk(sys_d_oe === e_soe, "R8", {15'h0, sys_d_oe}, {15'h0, e_soe});
      chk(sys_d_out === (e_soe ? ad_in : 8'h00), "R8", {8'h0, sys_d_out},
          {8'h0, e_soe ? ad_in : 8'h00});
      // R9
      e_aoe = rst_n && !rd_n && wr_n && !ale;
      chk(ad_oe === e_aoe, "R9", {15'h0, ad_oe}, {15'h0, e_aoe});
      chk(ad_out === (e_aoe ? sys_d_in : 8'h00), "R9", {8'h0, ad_out},
          {8'h0, e_aoe ? sys_d_in : 8'h00});
   endtask

   // one cycle: update model at edge from pre-edge inputs, drive, check at negedge
   task automatic step(input logic n_rst, input logic n_ale, input logic [7:0] n_ad,
                       input logic [7:0] n_hi, input logic n_rd, input logic n_wr,
                       input logic n_io, input logic n_inta, input logic [7:0] n_sd);
      @(posedge clk);
      if (!rst_n)   held = 8'h00;
      else if (ale) held = ad_in;
      #1;
      rst_n = n_rst; ale = n_ale; ad_in = n_ad; hi_addr = n_hi; rd_n = n_rd;
      wr_n = n_wr; io_sel = n_io; inta_n = n_inta; sys_d_in = n_sd;
      if (!rst_n) held = 8'h00;
      @(negedge clk);
      check_all();
   endtask

   initial begin
      int unused;
      unused = $urandom(32'd1234);
      rst_n = 1'b0; ale = 1'b1; ad_in = 8'h77; hi_addr = 8'h12; rd_n = 1'b0;
      wr_n = 1'b1; io_sel = 1'b0; inta_n = 1'b0; sys_d_in = 8'h55;
      @(negedge clk);
      // R10: reset holds every strobe idle even with active requests
      chk(mem_rd_n && mem_wr_n && io_rd_n && io_wr_n && int_ack_n && !sys_d_oe && !ad_oe,
          "R10", {11'h0, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, int_ack_n}, 16'h001f);
      chk(sys_addr[7:0] === 8'h00, "R10", {8'h0, sys_addr[7:0]}, 16'h0000);
      step(0, 1, 8'h77, 8'h12, 1, 1, 0, 1, 8'h00);
      step(1, 0, 8'h99, 8'h12, 1, 1, 0, 1, 8'h00);
      // R10: first cycle after release, no ale yet: low byte reads zero
      step(1, 0, 8'hC3, 8'h34, 1, 1, 0, 1, 8'h00);

      // directed memory write: address phase then data phase with changed lines (R2,R3,R5,R8)
      step(1, 1, 8'hA5, 8'hBE, 1, 1, 0, 1, 8'h00);
      step(1, 0, 8'h3C, 8'hBE, 1, 0, 0, 1, 8'h00);
      step(1, 0, 8'h5A, 8'hBE, 1, 0, 0, 1, 8'h00);
      // directed IO read (R4,R9)
      step(1, 1, 8'h0F, 8'h00, 1, 1, 1, 1, 8'hE1);
      step(1, 0, 8'hFF, 8'h00, 0, 1, 1, 1, 8'hE1);
      // R6 conflict: both asserted, in both spaces
      step(1, 0, 8'h11, 8'h00, 0, 0, 0, 1, 8'h22);
      step(1, 0, 8'h11, 8'h00, 0, 0, 1, 1, 8'h22);
      // R7 interrupt acknowledge
      step(1, 0, 8'h00, 8'hFF, 1, 1, 0, 0, 8'h00);
      // reset in mid-transfer clears stored byte (R10)
      step(1, 1, 8'hEE, 8'h01, 1, 1, 0, 1, 8'h00);
      step(0, 0, 8'h44, 8'h01, 1, 0, 1, 1, 8'h00);
      step(1, 0, 8'h44, 8'h01, 1, 0, 1, 1, 8'h00);

      // constrained random transfers
      for (int i = 0; i < N_RANDOM; i++) begin
         logic [3:0] r;
         r = 4'($urandom);
         step(($urandom % 97) != 0,
              (r[1:0] == 2'b00),
              8'($urandom), 8'($urandom),
              ($urandom % 3) == 0 ? 1'b1 : 1'($urandom),
              ($urandom % 3) == 0 ? 1'b1 : 1'($urandom),
              1'($urandom), ($urandom % 5) != 0,
              8'($urandom));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule